// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small 8-bit accumulator machine with one working register, A. Each instruction runs as a short series of micro-steps. A 2-bit step counter and the 4-bit opcode held in the instruction register together form a 6-bit address. That address selects one of 64 control words from a fixed, synthesizable micro-instruction store. Each word drives the individual control lines of the datapath for one clock.

Conditional branches do not need separate sequencing logic. When opcode bit 3 is set, a flag multiplexer replaces the low opcode bit of the store address with the selected, latched ALU condition. The taken and not-taken paths therefore sit in different store slots. Each of the four conditional jumps owns 8 words, so the jumps fill half of the store. The flags are captured from the ALU only on micro-steps that request it.

Top module: `useq_ctrl`

## Requirements
- R1: A synchronous active-high reset returns the step counter to step 0 and clears both latched flags. While reset is held, `ctrl_o` is 0x0009 and `step_reset_o` is 0. A reset in the middle of an instruction restarts at step 0.
- R2: For every opcode, step 0 outputs 0x0009 (PC to bus, address register load). Step 1 outputs 0x0052 (memory to bus, instruction register load, PC increment).
- R3: `step_reset_o` is high exactly on the step whose word has bit 14 (end of instruction) set. The counter is at step 0 on the following clock.
- R4: Control bit positions are: 0 pc_out, 1 pc_inc, 2 pc_load, 3 mar_in, 4 mem_out, 5 mem_in, 6 ir_in, 7 ir_out, 8 a_in, 9 a_out, 10 a_from_alu, 11 flag_en, 13:12 alu_op, 14 end.
- R5: Load-from-memory (opcode 0) gives 0x0088 at step 2 and then 0x4110. Store-to-memory (opcode 1) gives 0x0088 and then 0x4220.
- R6: The ALU opcodes are 2 add, 3 subtract, 4 AND and 5 OR. Each gives 0x0088 at step 2. At step 3 it gives 0x4C10 with alu_op set to 0, 1, 2 or 3 respectively, so the words are 0x4C10, 0x5C10, 0x6C10 and 0x7C10.
- R7: Load-immediate (opcode 6) gives 0x4180 at step 2 and ends there. Unconditional jump (opcode 7) gives 0x4084 at step 2 and ends there.
- R8: The latched zero and carry flags take the ALU flag inputs only at the clock ending a step with flag_en set. At all other times those inputs have no effect.
- R9: Conditional jumps are opcodes 8 (zero), 10 (carry), 12 (not zero) and 14 (not carry). Each is a 3-step instruction. Step 2 gives 0x4084 when the condition holds on the latched flags, and 0x4000 otherwise.
- R10: In a jump opcode, bit 0 has no effect. Opcodes 9, 11, 13 and 15 behave exactly like 8, 10, 12 and 14.
- R11: At most one of pc_out, mem_out, ir_out and a_out is high in any step, and a_in and a_from_alu are never both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 4 | Opcode currently held in the instruction register |
| alu_zero_i | input | 1 | Zero result flag from the ALU |
| alu_carry_i | input | 1 | Carry flag from the ALU |
| ctrl_o | output | 15 | Control word for the current micro-step |
| step_reset_o | output | 1 | High on the last micro-step of an instruction |

## Verification
Every opcode is sequenced through its full step series, and the words after fetch are compared. This separates the four instruction shapes: memory read, memory write, ALU and immediate or jump. It also shows whether the instruction ends after step 2 or step 3. The conditional jumps are run after ALU operations that leave opposite flag pairs (zero set with carry clear, then the reverse), so each condition is seen both taken and not taken. The ALU flag inputs are toggled during steps without flag_en, and a later jump shows whether they were wrongly captured. The odd jump aliases and a reset that arrives mid-instruction show whether the address bit substitution and the counter restart are right.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int OPC_W    = 4;
    localparam int STEP_W   = 2;
    localparam int UADDR_W  = OPC_W + STEP_W;
    localparam int UDEPTH   = 1 << UADDR_W;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_OR  = 2'd3
    } alu_op_e;

    typedef enum logic [OPC_W-1:0] {
        OP_LDM = 4'h0,
        OP_STM = 4'h1,
        OP_ADD = 4'h2,
        OP_SUB = 4'h3,
        OP_AND = 4'h4,
        OP_ORR = 4'h5,
        OP_LDI = 4'h6,
        OP_JMP = 4'h7
    } base_op_e;

    typedef struct packed {
        logic    end_i;
        alu_op_e alu_op;
        logic    flag_en;
        logic    a_from_alu;
        logic    a_out;
        logic    a_in;
        logic    ir_out;
        logic    ir_in;
        logic    mem_in;
        logic    mem_out;
        logic    mar_in;
        logic    pc_load;
        logic    pc_inc;
        logic    pc_out;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Content of one store word; jump regions use op[0] as the resolved condition.
    function automatic ctrl_t ucode_word(input logic [UADDR_W-1:0] addr);
        ctrl_t                w;
        logic [STEP_W-1:0]    st;
        logic [OPC_W-1:0]     op;
        w  = '0;
        st = addr[STEP_W-1:0];
        op = addr[UADDR_W-1:STEP_W];
        if (st == 2'd0) begin
            w.pc_out = 1'b1;
            w.mar_in = 1'b1;
        end else if (st == 2'd1) begin
            w.mem_out = 1'b1;
            w.ir_in   = 1'b1;
            w.pc_inc  = 1'b1;
        end else if (op[OPC_W-1]) begin
            w.end_i = 1'b1;
            if (st == 2'd2 && op[0]) begin
                w.ir_out  = 1'b1;
                w.pc_load = 1'b1;
            end
        end else begin
            case (base_op_e'(op))
                OP_LDI: begin
                    w.end_i = 1'b1;
                    if (st == 2'd2) begin
                        w.ir_out = 1'b1;
                        w.a_in   = 1'b1;
                    end
                end
                OP_JMP: begin
                    w.end_i = 1'b1;
                    if (st == 2'd2) begin
                        w.ir_out  = 1'b1;
                        w.pc_load = 1'b1;
                    end
                end
                default: begin
                    if (st == 2'd2) begin
                        w.ir_out = 1'b1;
                        w.mar_in = 1'b1;
                    end else begin
                        w.end_i = 1'b1;
                        if (base_op_e'(op) == OP_LDM) begin
                            w.mem_out = 1'b1;
                            w.a_in    = 1'b1;
                        end else if (base_op_e'(op) == OP_STM) begin
                            w.a_out  = 1'b1;
                            w.mem_in = 1'b1;
                        end else begin
                            w.mem_out    = 1'b1;
                            w.a_from_alu = 1'b1;
                            w.flag_en    = 1'b1;
                            w.alu_op     = alu_op_e'(op[1:0] + 2'd2);
                        end
                    end
                end
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/useq_step_ctr.sv
module useq_step_ctr
    import useq_pkg::*;
#(
    parameter int W = STEP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         last_step,
    output logic [W-1:0] step
);

    always_ff @(posedge clk) begin
        if (rst || last_step) begin
            step <= '0;
        end else begin
            step <= step + 1'b1;
        end
    end

endmodule

// File: rtl/useq_flag_sel.sv
module useq_flag_sel
    import useq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       capture,
    input  logic       alu_zero,
    input  logic       alu_carry,
    input  logic [1:0] cond,
    output logic       flag_z,
    output logic       flag_c,
    output logic       cond_true
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_z <= 1'b0;
            flag_c <= 1'b0;
        end else if (capture) begin
            flag_z <= alu_zero;
            flag_c <= alu_carry;
        end
    end

    always_comb begin
        case (cond)
            2'd0:    cond_true = flag_z;
            2'd1:    cond_true = flag_c;
            2'd2:    cond_true = ~flag_z;
            default: cond_true = ~flag_c;
        endcase
    end

endmodule

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
#(
    parameter int AW = UADDR_W
) (
    input  logic [AW-1:0] addr,
    output ctrl_t         word
);

    always_comb begin
        word = ucode_word(addr);
    end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int OW = OPC_W,
    parameter int SW = STEP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OW-1:0]     opcode_i,
    input  logic              alu_zero_i,
    input  logic              alu_carry_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              step_reset_o
);

    localparam int AW = OW + SW;

    logic [SW-1:0] step;
    logic [AW-1:0] uaddr;
    logic          flag_z;
    logic          flag_c;
    logic          cond_true;
    logic          low_bit;
    ctrl_t         word;

    useq_step_ctr #(.W(SW)) u_step (
        .clk       (clk),
        .rst       (rst),
        .last_step (word.end_i),
        .step      (step)
    );

    useq_flag_sel u_flags (
        .clk       (clk),
        .rst       (rst),
        .capture   (word.flag_en),
        .alu_zero  (alu_zero_i),
        .alu_carry (alu_carry_i),
        .cond      (opcode_i[2:1]),
        .flag_z    (flag_z),
        .flag_c    (flag_c),
        .cond_true (cond_true)
    );

    // Jump opcodes steer the low opcode address bit from the selected flag.
    assign low_bit = opcode_i[OW-1] ? cond_true : opcode_i[0];
    assign uaddr   = {opcode_i[OW-1:1], low_bit, step};

    useq_store #(.AW(AW)) u_store (
        .addr (uaddr),
        .word (word)
    );

    assign ctrl_o       = word;
    assign step_reset_o = word.end_i;

endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk
    import useq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CTRL_W-1:0] cw,
    input logic              step_rst,
    input logic [OPC_W-1:0]  opcode,
    input logic              flag_z,
    input logic              flag_c
);

    logic sel_flag;
    always_comb begin
        case (opcode[2:1])
            2'd0:    sel_flag = flag_z;
            2'd1:    sel_flag = flag_c;
            2'd2:    sel_flag = !flag_z;
            default: sel_flag = !flag_c;
        endcase
    end

    AST_ONE_BUS_DRIVER: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cw[0], cw[4], cw[7], cw[9]})); // R11
    AST_A_LOAD_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cw[8] && cw[10])); // R11
    AST_WRAP_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
        step_rst |=> (cw[0] && cw[3] && !step_rst)); // R3
    AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (rst)
        (cw[0] && cw[3]) |=> (cw[1] && cw[4] && cw[6])); // R2
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cw[11] |=> $stable({flag_z, flag_c})); // R8
    AST_TAKEN_ON_COND: assert property (@(posedge clk) disable iff (rst)
        (opcode[3] && cw[2]) |-> sel_flag); // R9

endmodule

bind useq_ctrl useq_ctrl_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .cw       (ctrl_o),
    .step_rst (step_reset_o),
    .opcode   (opcode_i),
    .flag_z   (flag_z),
    .flag_c   (flag_c)
);

// File: tb/useq_ctrl_tb_top.sv
`timescale 1ns/1ps
module useq_ctrl_tb_top;

    localparam logic [14:0] W_F0    = 15'h0009;
    localparam logic [14:0] W_F1    = 15'h0052;
    localparam logic [14:0] W_ADR   = 15'h0088;
    localparam logic [14:0] W_LDM   = 15'h4110;
    localparam logic [14:0] W_STM   = 15'h4220;
    localparam logic [14:0] W_LDI   = 15'h4180;
    localparam logic [14:0] W_JUMP  = 15'h4084;
    localparam logic [14:0] W_SKIP  = 15'h4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  opcode = 4'h0;
    logic        alu_z = 1'b0;
    logic        alu_c = 1'b0;
    logic [14:0] ctrl;
    logic        sreset;

    int total = 0;
    int bad   = 0;
    bit fz = 1'b0;
    bit fc = 1'b0;

    always #2 clk = ~clk;

    useq_ctrl dut_i (
        .clk          (clk),
        .rst          (rst),
        .opcode_i     (opcode),
        .alu_zero_i   (alu_z),
        .alu_carry_i  (alu_c),
        .ctrl_o       (ctrl),
        .step_reset_o (sreset)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Runs one instruction from step 0 (at a negedge) and ends at the next step 0.
    task automatic run_op(input logic [3:0] op, input logic [14:0] e2,
                          input logic [14:0] e3, input bit four, input string req);
        opcode = op;
        chk("R2 fetch0", {1'b0, ctrl}, {1'b0, W_F0});
        @(negedge clk);
        chk("R2 fetch1", {1'b0, ctrl}, {1'b0, W_F1});
        @(negedge clk);
        chk(req, {1'b0, ctrl}, {1'b0, e2});
        chk("R3 end flag step2", {15'b0, sreset}, {15'b0, !four});
        if (four) begin
            @(negedge clk);
            chk(req, {1'b0, ctrl}, {1'b0, e3});
            chk("R3 end flag step3", {15'b0, sreset}, 16'd1);
        end
        @(negedge clk);
        chk("R3 back to step0", {sreset, ctrl}, {1'b0, W_F0});
    endtask

    function automatic bit cond_of(input logic [3:0] op);
        case (op[2:1])
            2'd0:    return fz;
            2'd1:    return fc;
            2'd2:    return !fz;
            default: return !fc;
        endcase
    endfunction

    task automatic run_jump(input logic [3:0] op, input string req);
        run_op(op, cond_of(op) ? W_JUMP : W_SKIP, 15'h0, 1'b0, req);
    endtask

    task automatic run_alu(input logic [3:0] op, input bit z, input bit c);
        logic [14:0] e3;
        e3 = 15'h4C10 | ({13'b0, 2'(op - 4'd2)} << 12);
        alu_z = z;
        alu_c = c;
        run_op(op, W_ADR, e3, 1'b1, "R6 alu op");
        fz = z;
        fc = c;
        alu_z = !z;
        alu_c = !c;
    endtask

    task automatic t_reset;
        alu_z = 1'b1;
        alu_c = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset word", {sreset, ctrl}, {1'b0, W_F0});
        rst = 1'b0;
        alu_z = 1'b0;
        alu_c = 1'b0;
        fz = 1'b0;
        fc = 1'b0;
        run_jump(4'h8, "R1 zero flag cleared");
        run_jump(4'hA, "R1 carry flag cleared");
    endtask

    task automatic t_mem;
        run_op(4'h0, W_ADR, W_LDM, 1'b1, "R5 load mem");
        run_op(4'h1, W_ADR, W_STM, 1'b1, "R5 store mem");
        chk("R4 store bits a_out mem_in end", {1'b0, W_STM},
            16'((1 << 9) | (1 << 5) | (1 << 14)));
    endtask

    task automatic t_imm_jmp;
        run_op(4'h6, W_LDI, 15'h0, 1'b0, "R7 load immediate");
        run_op(4'h7, W_JUMP, 15'h0, 1'b0, "R7 jump");
    endtask

    task automatic t_cond;
        run_alu(4'h2, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) run_jump(4'(8 + 2 * k), "R9 cond after z=1 c=0");
        run_alu(4'h3, 1'b0, 1'b1);
        for (int k = 0; k < 4; k++) run_jump(4'(8 + 2 * k), "R9 cond after z=0 c=1");
        run_alu(4'h4, 1'b1, 1'b1);
        run_alu(4'h5, 1'b0, 1'b0);
        run_jump(4'hC, "R9 not zero taken");
    endtask

    task automatic t_flag_hold;
        run_alu(4'h2, 1'b1, 1'b1);
        alu_z = 1'b0;
        alu_c = 1'b0;
        run_op(4'h0, W_ADR, W_LDM, 1'b1, "R8 load with flags toggled");
        run_op(4'h6, W_LDI, 15'h0, 1'b0, "R8 imm with flags toggled");
        run_jump(4'h8, "R8 zero kept");
        run_jump(4'hA, "R8 carry kept");
    endtask

    task automatic t_alias;
        run_alu(4'h3, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) run_jump(4'(9 + 2 * k), "R10 odd alias");
    endtask

    task automatic t_mid_reset;
        opcode = 4'h0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 mid step2", {1'b0, ctrl}, {1'b0, W_ADR});
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 restart after mid reset", {sreset, ctrl}, {1'b0, W_F0});
        fz = 1'b0;
        fc = 1'b0;
        run_jump(4'hE, "R1 flags cleared by mid reset");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_mem();
        t_imm_jmp();
        t_cond();
        t_flag_hold();
        t_alias();
        t_mid_reset();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule